// File: doc/BRIEF.md
# Serial-Access SRAM Slave

This block puts a byte-wide on-chip memory behind a four-wire serial slave port. A host lowers chip select, shifts in an 8-bit opcode and a 16-bit address (MSB first, sampled on rising SCK), and then either shifts data bytes in or receives them on the serial output. The output changes on falling SCK. The address pointer steps after every byte according to a two-bit access mode held in a small mode register. Word mode moves one byte. Page mode loops inside a 32-byte page. Burst mode streams across the array. Raising chip select ends any operation at any point. A pause input freezes the transfer in place.

All four serial pins are oversampled by the system clock through synchronizers, so the block sits in one clock domain. SCK must stay below a quarter of the system clock rate, with each level held for at least four system clocks. The serial stream has no valid/ready handshake. The host sets the pace with SCK, and the only way to stall is the pause input. The array is 2^AW bytes. AW = 13 gives the full 8K x 8 organisation; the default build uses a smaller array.

Top module: `spi_sram_slave`

## Requirements
- R1: After reset and whenever chip select is high, so_oe is low. The mode register resets to word mode (bits [7:6] = 00).
- R2: Every transaction is an 8-bit opcode followed by a 16-bit address, both MSB first on rising SCK. Address bits at and above AW are ignored, so addresses that differ only there select the same byte.
- R3: Opcode 8'h02 writes. Each following group of 8 SI bits, MSB first, is stored at the current pointer. so_oe stays low for the whole transaction.
- R4: Opcode 8'h03 reads. Bit 7 of the addressed byte is on SO after the falling SCK edge that follows the last address bit, and the remaining bits follow one per falling edge. so_oe is high while read data is driven.
- R5: In word mode (00), one data byte completes the access. Further bits are ignored, nothing more is written, and so_oe is low until chip select rises.
- R6: In page mode (10), the pointer steps within its 32-byte page and wraps from word 31 to word 0 of the same page, for both reads and writes.
- R7: In burst mode (01), a write steps the pointer across the whole array and wraps from the top address to 0.
- R8: In burst mode, a read steps through the page, wraps to word 0 of that page and counts up to the start word. The pointer then moves to the same word of the next page, and the sequence repeats.
- R9: Opcode 8'h01 followed by one byte loads that byte's bits [7:6] into the mode register. Opcode 8'h05 returns the register in bits [7:6] with zeros below.
- R10: Raising chip select ends the operation at once. A partly shifted byte is never written.
- R11: While hold_n is low, SCK and SI edges are ignored and so_oe is low. When hold_n is released, the transfer resumes at the exact bit where it stopped.
- R12: Any other opcode is ignored. The rest of the transaction leaves memory and the mode register untouched, and so_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
Single-byte accesses at aliased addresses show whether the upper address bits are really dropped. Extra bytes sent in word mode show whether the access stops after one byte. A page write that starts two words before the page end, read back across that end, separates an in-page wrap from a carry into the next page. A 34-byte burst read starting mid-page separates the wrap-to-start-word rule from plain sequential stepping. A burst write across the top address checks the wrap to 0. Transfers that are cut short by chip select or paused mid-byte while SCK and SI toggle show whether partial bytes leak into memory and whether a paused transfer resumes at the right bit.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;
  typedef enum logic [1:0] {
    MODE_WORD  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_PAGE  = 2'b10,
    MODE_RSVD  = 2'b11
  } acc_mode_t;

  localparam logic [7:0] OP_SETMODE = 8'h01;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_GETMODE = 8'h05;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_MSET, PH_MGET, PH_DONE
  } phase_t;
endpackage

// File: rtl/spi_sram_front.sv
module spi_sram_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic held,
  output logic si_s,
  output logic rise,
  output logic fall
);
  // bit 3 sck, bit 2 cs_n, bit 1 si, bit 0 hold_n
  localparam logic [3:0] IDLE_PINS = 4'b0101;

  logic [3:0] stg [SYNC];
  logic       sck_q;
  logic [3:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) stg[i] <= IDLE_PINS;
      sck_q <= 1'b0;
    end else begin
      stg[0] <= {sck, cs_n, si, hold_n};
      for (int i = 1; i < SYNC; i++) stg[i] <= stg[i-1];
      sck_q <= stg[SYNC-1][3];
    end
  end

  assign cur  = stg[SYNC-1];
  assign sel  = !cur[2];
  assign held = !cur[0];
  assign si_s = cur[1];
  assign rise = sel && !held && cur[3] && !sck_q;
  assign fall = sel && !held && !cur[3] && sck_q;
endmodule

// File: rtl/spi_sram_step.sv
module spi_sram_step
  import spi_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 5
) (
  input  acc_mode_t         mode,
  input  logic              is_read,
  input  logic [AW-1:0]     ptr,
  input  logic [PW-1:0]     start_word,
  output logic [AW-1:0]     nxt
);
  localparam int GW = AW - PW;

  logic [GW-1:0] page;
  logic [PW-1:0] wnext;

  assign page  = ptr[AW-1:PW];
  assign wnext = ptr[PW-1:0] + 1'b1;

  always_comb begin
    unique case (mode)
      MODE_PAGE:  nxt = {page, wnext};
      MODE_BURST: begin
        if (!is_read)                nxt = ptr + 1'b1;
        else if (wnext == start_word) nxt = {page + 1'b1, wnext};
        else                         nxt = {page, wnext};
      end
      default:    nxt = ptr;
    endcase
  end
endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  p_write_addr_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(waddr));
endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import spi_sram_pkg::*;
#(
  parameter int AW   = 10,
  parameter int PW   = 5,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int ABITS = 16;
  localparam int CW    = $clog2(ABITS);

  logic sel, held, si_s, rise, fall;
  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [ABITS-1:0]  sreg, sh;
  logic [AW-1:0]     ptr, nxt;
  logic [PW-1:0]     start_word;
  acc_mode_t         mode;
  logic              is_read, oe_q, we, rd_adv, single;
  logic [7:0]        rdata, out_byte;

  spi_sram_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .sel(sel), .held(held), .si_s(si_s), .rise(rise), .fall(fall));

  spi_sram_step #(.AW(AW), .PW(PW)) u_step (
    .mode(mode), .is_read(is_read), .ptr(ptr), .start_word(start_word), .nxt(nxt));

  spi_sram_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(sh[7:0]),
    .raddr(ptr), .rdata(rdata));

  assign sh       = {sreg[ABITS-2:0], si_s};
  assign we       = rise && (phase == PH_WDATA) && (cnt == CW'(7));
  assign rd_adv   = rise && (phase == PH_RDATA) && (cnt == CW'(7));
  assign single   = (mode != MODE_PAGE) && (mode != MODE_BURST);
  assign out_byte = (phase == PH_MGET) ? {2'(mode), 6'b0} : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      cnt        <= '0;
      sreg       <= '0;
      ptr        <= '0;
      start_word <= '0;
      mode       <= MODE_WORD;
      is_read    <= 1'b0;
    end else if (!sel) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else if (rise) begin
      cnt <= cnt + 1'b1;
      unique case (phase)
        PH_CMD: begin
          sreg <= sh;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            unique case (sh[7:0])
              OP_WRITE:   begin phase <= PH_ADDR; is_read <= 1'b0; end
              OP_READ:    begin phase <= PH_ADDR; is_read <= 1'b1; end
              OP_SETMODE: phase <= PH_MSET;
              OP_GETMODE: phase <= PH_MGET;
              default:    phase <= PH_DONE;
            endcase
          end
        end
        PH_ADDR: begin
          sreg <= sh;
          if (cnt == CW'(ABITS-1)) begin
            cnt        <= '0;
            ptr        <= sh[AW-1:0];
            start_word <= sh[PW-1:0];
            phase      <= is_read ? PH_RDATA : PH_WDATA;
          end
        end
        PH_WDATA, PH_RDATA: begin
          sreg <= sh;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            ptr <= nxt;
            if (single) phase <= PH_DONE;
          end
        end
        PH_MSET: begin
          sreg <= sh;
          if (cnt == CW'(7)) begin
            mode  <= acc_mode_t'(sh[7:6]);
            phase <= PH_DONE;
          end
        end
        PH_MGET: if (cnt == CW'(7)) phase <= PH_DONE;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so   <= 1'b0;
      oe_q <= 1'b0;
    end else if (!sel) begin
      so   <= 1'b0;
      oe_q <= 1'b0;
    end else if (fall) begin
      if (phase == PH_RDATA || phase == PH_MGET) begin
        so   <= out_byte[3'd7 - cnt[2:0]];
        oe_q <= 1'b1;
      end else begin
        oe_q <= 1'b0;
      end
    end
  end

  assign so_oe = oe_q && !held;

  p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe);
  p_write_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WDATA) |-> !so_oe);
  p_word_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode == MODE_WORD) |=> (phase == PH_DONE || !sel));
  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((we || rd_adv) && mode == MODE_PAGE) |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));
  p_burst_rd_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && mode == MODE_BURST && PW'(ptr[PW-1:0] + 1'b1) != start_word)
      |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));
  p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sel) |=> ($stable(cnt) && $stable(phase)));
endmodule

// File: tb/spi_sram_slave_bench.sv
module spi_sram_slave_bench;
  localparam int AW   = 10;
  localparam int TOP  = (1 << AW) - 1;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  int checks = 0, errors = 0;
  logic [7:0] model [1 << AW];

  always #4 clk = ~clk;

  spi_sram_slave #(.AW(AW)) u_spi_sram_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic rx, output logic oe);
    si = b;
    wait_half();
    rx = so;
    oe = so_oe;
    sck = 1'b1;
    wait_half();
    sck = 1'b0;
  endtask

  task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx, output logic any_oe);
    logic r, o;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(tx[i], r, o);
      rx[i] = r;
      any_oe |= o;
    end
  endtask

  task automatic sel_on();
    @(negedge clk);
    cs_n = 1'b0;
    wait_half();
  endtask

  task automatic sel_off();
    wait_half();
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic head(input logic [7:0] op, input logic [15:0] addr, output logic any_oe);
    logic [7:0] d;
    logic o1, o2, o3;
    byte_xfer(op, d, o1);
    byte_xfer(addr[15:8], d, o2);
    byte_xfer(addr[7:0], d, o3);
    any_oe = o1 | o2 | o3;
  endtask

  task automatic set_mode(input logic [7:0] m);
    logic [7:0] d;
    logic o;
    sel_on();
    byte_xfer(8'h01, d, o);
    byte_xfer(m, d, o);
    sel_off();
  endtask

  task automatic get_mode(output logic [7:0] m);
    logic [7:0] d;
    logic o;
    sel_on();
    byte_xfer(8'h05, d, o);
    byte_xfer(8'h00, m, o);
    sel_off();
  endtask

  task automatic rd1(input int a, output logic [7:0] v);
    logic o;
    sel_on();
    head(8'h03, 16'(a), o);
    byte_xfer(8'h00, v, o);
    sel_off();
  endtask

  task automatic wr1(input int a, input logic [7:0] v);
    logic [7:0] d;
    logic o;
    sel_on();
    head(8'h02, 16'(a), o);
    byte_xfer(v, d, o);
    sel_off();
    model[a & TOP] = v;
  endtask

  task automatic t_reset();
    logic [7:0] m;
    repeat (6) @(negedge clk);
    check("R1 so_oe after reset", so_oe, 1'b0);
    get_mode(m);
    check("R1 reset mode", m, 8'h00);
  endtask

  task automatic t_word();
    logic [7:0] d, v;
    logic o, o2;
    set_mode(8'h00);
    wr1(16'h0124, 8'h11);
    sel_on();
    head(8'h02, 16'h0123, o);
    byte_xfer(8'hA5, d, o2);
    byte_xfer(8'h3C, d, o2);
    sel_off();
    model[16'h123] = 8'hA5;
    check("R3 so_oe low in write", o | o2, 1'b0);
    sel_on();
    head(8'h03, 16'h0123, o);
    byte_xfer(8'h00, v, o);
    check("R4 read byte", v, 8'hA5);
    check("R4 so_oe during read", o, 1'b1);
    byte_xfer(8'h00, d, o2);
    check("R5 so_oe after one byte", o2, 1'b0);
    sel_off();
    rd1(16'h0124, v);
    check("R5 neighbour untouched", v, 8'h11);
    wr1(16'hFC40, 8'h77);
    rd1(16'h0040, v);
    check("R2 upper address bits ignored", v, 8'h77);
  endtask

  task automatic t_page();
    logic [7:0] d, m;
    logic o;
    set_mode(8'h80);
    get_mode(m);
    check("R9 mode readback", m, 8'h80);
    sel_on();
    head(8'h02, 16'd64, o);
    for (int i = 0; i < 32; i++) begin
      byte_xfer(8'(8'h20 + i), d, o);
      model[64 + i] = 8'(8'h20 + i);
    end
    sel_off();
    sel_on();
    head(8'h02, 16'd94, o);
    byte_xfer(8'h10, d, o); model[94] = 8'h10;
    byte_xfer(8'h11, d, o); model[95] = 8'h11;
    byte_xfer(8'h12, d, o); model[64] = 8'h12;
    sel_off();
    sel_on();
    head(8'h03, 16'd94, o);
    byte_xfer(8'h00, d, o); check("R6 page read w30", d, model[94]);
    byte_xfer(8'h00, d, o); check("R6 page read w31", d, model[95]);
    byte_xfer(8'h00, d, o); check("R6 page wrap to w0", d, model[64]);
    byte_xfer(8'h00, d, o); check("R6 page w1", d, model[65]);
    sel_off();
  endtask

  task automatic t_burst_write();
    logic [7:0] d;
    logic o;
    set_mode(8'h40);
    sel_on();
    head(8'h02, 16'(TOP - 1), o);
    byte_xfer(8'hE0, d, o); model[TOP - 1] = 8'hE0;
    byte_xfer(8'hE1, d, o); model[TOP] = 8'hE1;
    byte_xfer(8'hE2, d, o); model[0] = 8'hE2;
    sel_off();
    set_mode(8'h00);
    rd1(TOP, d);
    check("R7 burst top", d, 8'hE1);
    rd1(0, d);
    check("R7 burst wrap to 0", d, 8'hE2);
  endtask

  task automatic t_burst_read();
    logic [7:0] d;
    logic o;
    int pg, w, bad;
    set_mode(8'h40);
    sel_on();
    head(8'h02, 16'd32, o);
    for (int i = 0; i < 64; i++) begin
      byte_xfer(8'(i * 7 + 3), d, o);
      model[32 + i] = 8'(i * 7 + 3);
    end
    sel_off();
    sel_on();
    head(8'h03, 16'd62, o);
    pg = 1; w = 30; bad = 0;
    for (int k = 0; k < 34; k++) begin
      byte_xfer(8'h00, d, o);
      if (d !== model[pg * 32 + w]) begin
        bad++;
        $display("FAIL R8 burst read step %0d got %0h expected %0h", k, d, model[pg * 32 + w]);
      end
      w = (w + 1) % 32;
      if (w == 30) pg++;
    end
    sel_off();
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic t_abort();
    logic [7:0] d;
    logic r, o;
    set_mode(8'h00);
    wr1(200, 8'h99);
    sel_on();
    head(8'h02, 16'd200, o);
    for (int i = 0; i < 5; i++) bit_xfer(1'b0, r, o);
    sel_off();
    rd1(200, d);
    check("R10 partial byte dropped", d, 8'h99);
  endtask

  task automatic t_hold();
    logic [7:0] v, d;
    logic r, o, oe_hold;
    sel_on();
    head(8'h02, 16'd300, o);
    for (int i = 7; i >= 4; i--) bit_xfer(v_bit(8'hC6, i), r, o);
    hold_n = 1'b0;
    wait_half();
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, r, o);
    hold_n = 1'b1;
    wait_half();
    for (int i = 3; i >= 0; i--) bit_xfer(v_bit(8'hC6, i), r, o);
    sel_off();
    model[300] = 8'hC6;
    rd1(300, d);
    check("R11 write resumed after hold", d, 8'hC6);
    sel_on();
    head(8'h03, 16'd300, o);
    for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, r, o); v[i] = r; end
    hold_n = 1'b0;
    wait_half();
    wait_half();
    oe_hold = so_oe;
    hold_n = 1'b1;
    wait_half();
    for (int i = 4; i >= 0; i--) begin bit_xfer(1'b0, r, o); v[i] = r; end
    sel_off();
    check("R11 so_oe low in hold", oe_hold, 1'b0);
    check("R11 read resumed after hold", v, 8'hC6);
  endtask

  function automatic logic v_bit(input logic [7:0] b, input int i);
    return b[i];
  endfunction

  task automatic t_unknown();
    logic [7:0] d, m;
    logic o, o2;
    sel_on();
    byte_xfer(8'h07, d, o);
    byte_xfer(8'h00, d, o2);
    byte_xfer(8'h40, d, o);
    sel_off();
    check("R12 so_oe stays low", o | o2, 1'b0);
    get_mode(m);
    check("R12 mode untouched", m, 8'h00);
    check("R1 so_oe with cs high", so_oe, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_page();
    t_burst_write();
    t_burst_read();
    t_abort();
    t_hold();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule